// File: doc/BRIEF.md
# Barrel Time-Shared Processor Sequencer

This block shares one execution slot among ten virtual processors. It holds no per-processor hardware. Instead, every processor's working state sits in a ring of context registers, and the ring shifts by one stage on every clock (one minor cycle). At any moment the context at the head of the ring is the one in the slot. The external slot logic receives that context, performs one step of the current instruction, and returns a new program address and accumulator, together with a flag that says whether the instruction has finished.

The block packs the returned values and an updated step counter into the tail of the ring. That context then travels back to the head, so it is presented again exactly one revolution later. One revolution is ten clocks, which is one major cycle. An instruction that needs several steps gets one step on each revolution. A memory access that a processor starts during one visit has the full revolution to finish before that processor's next visit.

A pulse marks the clock in which processor 0 is in the slot, which is the start of each major cycle.

Top module: `barrel_slot_seq`

## Requirements
- R1: While the synchronous active-high reset is asserted, the slot index is set to 0 and every context is cleared. In the first ten clocks after reset is released, each processor is presented with program address 0, accumulator 0 and step 0.
- R2: The slot index rises by one on every clock and wraps from 9 back to 0.
- R3: The major-cycle pulse is high exactly in those clocks in which the slot index is 0, so it lasts one clock out of every ten.
- R4: The program address and accumulator presented for a processor are the values returned for that processor at its previous visit, ten clocks earlier.
- R5: The step field of a processor's context rises by one after a visit whose done flag is 0, and is cleared to 0 after a visit whose done flag is 1.
- R6: A visit changes only the context of the processor that is in the slot. The contexts of all other processors are presented unchanged.
- R7: The slot context is laid out with the program address in bits 51:34, the accumulator in bits 33:16 and the step field in bits 15:0.
- R8: A reset applied in the middle of operation brings back the state described in R1, whatever the ring held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Minor-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_idx_o | output | 4 | Index of the processor currently in the slot |
| major_start_o | output | 1 | High while processor 0 is in the slot |
| slot_ctx_o | output | 52 | Context entering the slot |
| ret_pc_i | input | 18 | Program address returned by the slot logic |
| ret_acc_i | input | 18 | Accumulator returned by the slot logic |
| step_done_i | input | 1 | The instruction of the current processor is complete |

## Verification
Any fault in the ring shows up at the slot ten clocks after the faulty write, because that is when the damaged context comes back to the head. Writing to the wrong stage, dropping a stage or skipping the tail update all show up within one revolution as a wrong address, accumulator or step value for a specific processor. A counter fault shows up within a single clock as a mismatched index or a misplaced major-cycle pulse. The bench therefore compares every output on every clock against its own ten-entry model.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
   // Default geometry of the sequencer
   localparam int unsigned DEF_PROCS = 10;
   localparam int unsigned DEF_PC_W  = 18;
   localparam int unsigned DEF_ACC_W = 18;
   localparam int unsigned DEF_PH_W  = 16;
   localparam int unsigned DEF_CTX_W = DEF_PC_W + DEF_ACC_W + DEF_PH_W;
endpackage

// File: rtl/barrel_slot_ctr.sv
module barrel_slot_ctr #(
   parameter int unsigned N_PROC = barrel_pkg::DEF_PROCS,
   localparam int unsigned IDX_W = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [IDX_W-1:0] idx_o,
   output logic             major_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PROC - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst)                idx_q <= '0;
      else if (idx_q == LAST) idx_q <= '0;
      else                    idx_q <= idx_q + IDX_W'(1);
   end

   assign idx_o   = idx_q;
   assign major_o = (idx_q == '0);

   // R2: the index wraps after the last processor
   a_r2_idx_wrap: assert property (@(posedge clk) disable iff (rst)
      (idx_q == LAST) |=> (idx_q == '0));
   // R2: otherwise the index rises by one
   a_r2_idx_step: assert property (@(posedge clk) disable iff (rst)
      (idx_q != LAST) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
   // R3: the last processor is always followed by a major-cycle start
   a_r3_major_follows_last: assert property (@(posedge clk) disable iff (rst)
      (idx_q == LAST) |=> major_o);
endmodule

// File: rtl/barrel_ctx_ring.sv
module barrel_ctx_ring #(
   parameter int unsigned N_PROC = barrel_pkg::DEF_PROCS,
   parameter int unsigned CTX_W  = barrel_pkg::DEF_CTX_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CTX_W-1:0] tail_wr_i,
   output logic [CTX_W-1:0] head_o
);
   logic [CTX_W-1:0] stage_q [N_PROC];

   // Each stage takes the value of the stage behind it; the tail takes the returned context
   for (genvar s = 0; s < N_PROC; s++) begin : g_stage
      if (s == N_PROC - 1) begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= tail_wr_i;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s+1];
         end
      end
   end

   assign head_o = stage_q[0];

   // R4: the tail holds exactly what the slot returned one clock earlier
   a_r4_tail_capture: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (stage_q[N_PROC-1] == $past(tail_wr_i)));
   // R6: the head advances by one stage and nothing else is altered on the way
   a_r6_head_shift: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (stage_q[0] == $past(stage_q[1])));
endmodule

// File: rtl/barrel_ctx_merge.sv
module barrel_ctx_merge #(
   parameter int unsigned PC_W  = barrel_pkg::DEF_PC_W,
   parameter int unsigned ACC_W = barrel_pkg::DEF_ACC_W,
   parameter int unsigned PH_W  = barrel_pkg::DEF_PH_W,
   localparam int unsigned CTX_W = PC_W + ACC_W + PH_W
) (
   input  logic [CTX_W-1:0] cur_ctx_i,
   input  logic [PC_W-1:0]  ret_pc_i,
   input  logic [ACC_W-1:0] ret_acc_i,
   input  logic             done_i,
   output logic [CTX_W-1:0] nxt_ctx_o
);
   logic [PH_W-1:0] cur_ph, nxt_ph;

   assign cur_ph = cur_ctx_i[PH_W-1:0];

   always_comb begin
      if (done_i) nxt_ph = '0;
      else        nxt_ph = cur_ph + PH_W'(1);
   end

   assign nxt_ctx_o = {ret_pc_i, ret_acc_i, nxt_ph};
endmodule

// File: rtl/barrel_slot_seq.sv
module barrel_slot_seq #(
   parameter int unsigned N_PROC = barrel_pkg::DEF_PROCS,
   parameter int unsigned PC_W   = barrel_pkg::DEF_PC_W,
   parameter int unsigned ACC_W  = barrel_pkg::DEF_ACC_W,
   parameter int unsigned PH_W   = barrel_pkg::DEF_PH_W,
   localparam int unsigned CTX_W = PC_W + ACC_W + PH_W,
   localparam int unsigned IDX_W = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [IDX_W-1:0] slot_idx_o,
   output logic             major_start_o,
   output logic [CTX_W-1:0] slot_ctx_o,
   input  logic [PC_W-1:0]  ret_pc_i,
   input  logic [ACC_W-1:0] ret_acc_i,
   input  logic             step_done_i
);
   initial begin
      assert (N_PROC >= 2) else $error("ring needs at least two processors");
      assert (PC_W > 0 && ACC_W > 0 && PH_W > 0) else $error("context fields must be non-empty");
   end

   logic [CTX_W-1:0] head_ctx, upd_ctx;

   barrel_slot_ctr #(.N_PROC(N_PROC)) u_ctr (
      .clk(clk), .rst(rst), .idx_o(slot_idx_o), .major_o(major_start_o)
   );

   barrel_ctx_merge #(.PC_W(PC_W), .ACC_W(ACC_W), .PH_W(PH_W)) u_merge (
      .cur_ctx_i(head_ctx), .ret_pc_i(ret_pc_i), .ret_acc_i(ret_acc_i),
      .done_i(step_done_i), .nxt_ctx_o(upd_ctx)
   );

   barrel_ctx_ring #(.N_PROC(N_PROC), .CTX_W(CTX_W)) u_ring (
      .clk(clk), .rst(rst), .tail_wr_i(upd_ctx), .head_o(head_ctx)
   );

   assign slot_ctx_o = head_ctx;

   // R1: the first clock after reset has processor 0 in the slot
   a_r1_reset_idx: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (slot_idx_o == '0));
   // R3: the pulse lasts a single clock
   a_r3_major_single: assert property (@(posedge clk) disable iff (rst)
      major_start_o |=> !major_start_o);
   // R3: the pulse only appears at processor 0
   a_r3_major_at_zero: assert property (@(posedge clk) disable iff (rst)
      major_start_o |-> (slot_idx_o == '0));
endmodule

// File: tb/barrel_slot_seq_tb_top.sv
`timescale 1ns/1ps
module barrel_slot_seq_tb_top;
   localparam int NP = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  slot_idx;
   logic        major;
   logic [51:0] slot_ctx;
   logic [17:0] ret_pc  = '0;
   logic [17:0] ret_acc = '0;
   logic        done    = 1'b0;

   always #2 clk = ~clk;

   barrel_slot_seq dut_i (
      .clk(clk), .rst(rst), .slot_idx_o(slot_idx), .major_start_o(major),
      .slot_ctx_o(slot_ctx), .ret_pc_i(ret_pc), .ret_acc_i(ret_acc),
      .step_done_i(done)
   );

   // stimulus vectors: {done, pc increment, accumulator xor mask}
   localparam logic [36:0] VEC [16] = '{
      {1'b0, 18'd1,     18'h000ff}, {1'b1, 18'd2,     18'h3ff00},
      {1'b0, 18'd3,     18'h15555}, {1'b0, 18'd7,     18'h2aaaa},
      {1'b1, 18'd100,   18'h00001}, {1'b0, 18'd5,     18'h3ffff},
      {1'b0, 18'h3ffff, 18'h12345}, {1'b1, 18'd11,    18'h0f0f0},
      {1'b0, 18'd4,     18'h30303}, {1'b0, 18'd9,     18'h00000},
      {1'b0, 18'd13,    18'h2468a}, {1'b1, 18'd1,     18'h13579},
      {1'b0, 18'd2,     18'h3c3c3}, {1'b1, 18'd6,     18'h00f00},
      {1'b0, 18'd8,     18'h1fffe}, {1'b0, 18'd17,    18'h20001}
   };

   int n_cmp = 0;
   int n_err = 0;
   bit summary_done = 0;
   logic [51:0] model [NP];
   int exp_idx = 0;

   task automatic chk(input string req, input logic [51:0] act, input logic [51:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!summary_done) begin
         summary_done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      end
   endtask

   // Called at a falling edge: compare the outputs, drive the return, update the model
   task automatic step(input logic dn, input logic [17:0] dpc, input logic [17:0] xacc,
                       input string ctx_tag);
      logic [17:0] mpc, macc;
      logic [15:0] mph;
      mpc  = model[exp_idx][51:34];
      macc = model[exp_idx][33:16];
      mph  = model[exp_idx][15:0];
      chk("R2 slot index", 52'(slot_idx), 52'(exp_idx));
      chk("R3 major pulse", 52'(major), 52'(exp_idx == 0));
      chk({ctx_tag, " address/accumulator"}, 52'(slot_ctx[51:16]), 52'({mpc, macc}));
      chk({ctx_tag, " R5 step field"}, 52'(slot_ctx[15:0]), 52'(mph));
      ret_pc  = mpc + dpc;
      ret_acc = macc ^ xacc;
      done    = dn;
      model[exp_idx] = {ret_pc, ret_acc, dn ? 16'd0 : mph + 16'd1};
      exp_idx = (exp_idx + 1) % NP;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int p = 0; p < NP; p++) model[p] = '0;
      exp_idx = 0;
   endtask

   initial begin
      #(4 * 100000);
      n_err++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: the first revolution after reset presents cleared contexts
      for (int k = 0; k < NP; k++) step(1'b0, 18'd0, 18'd0, "R1");
      // R4 R5 R6: table walk, model compared on every clock
      for (int k = 0; k < 80; k++) begin
         logic [36:0] v;
         v = VEC[k % 16];
         step(v[36], v[35:18], v[17:0], "R4");
      end
      // R5: ten revolutions without completion, step field counts up
      for (int k = 0; k < 10 * NP; k++) step(1'b0, 18'd1, 18'd0, "R5");
      chk("R5 step count of current slot", 52'(slot_ctx[15:0]), 52'(model[exp_idx][15:0]));
      // R5: one revolution with completion clears every step field
      for (int k = 0; k < NP; k++) step(1'b1, 18'd0, 18'd0, "R5");
      for (int k = 0; k < NP; k++) step(1'b0, 18'd0, 18'd0, "R5 cleared");
      // R6: only processor 3 is changed; everyone else is returned as is
      for (int k = 0; k < 2 * NP; k++) begin
         if (exp_idx == 3) step(1'b0, 18'd77, 18'h3ffff, "R6");
         else              step(1'b0, 18'd0, 18'd0, "R6");
      end
      // R7: field placement at bit positions 51:34, 33:16, 15:0
      while (exp_idx != 5) step(1'b0, 18'd0, 18'd0, "R7");
      begin
         logic [17:0] dpc;
         dpc = 18'h3ffff - model[5][51:34];
         step(1'b1, dpc, model[5][33:16], "R7");
      end
      for (int k = 0; k < NP - 1; k++) step(1'b0, 18'd0, 18'd0, "R7");
      chk("R7 address bits 51:34", 52'(slot_ctx[51:34]), 52'(18'h3ffff));
      chk("R7 accumulator bits 33:16", 52'(slot_ctx[33:16]), 52'(0));
      chk("R7 step bits 15:0", 52'(slot_ctx[15:0]), 52'(0));
      // R8: reset in the middle of activity
      for (int k = 0; k < 7; k++) step(1'b0, 18'd9, 18'h2b2b2, "R4");
      do_reset();
      chk("R8 index after reset", 52'(slot_idx), 52'(0));
      chk("R8 major after reset", 52'(major), 52'(1));
      for (int k = 0; k < NP; k++) step(1'b0, 18'd0, 18'd0, "R8 R1");
      for (int k = 0; k < 30; k++) step(1'b0, 18'(k), 18'(k * 3), "R4");
      report();
      $finish;
   end
endmodule